// File: doc/BRIEF.md
# AVS Voltage Write Frame Handler

This block sits behind an adaptive voltage scaling slave interface. It takes the voltage field of a decoded write frame and a commit strobe, and turns them into the 10-bit reference code that drives the regulator DAC. Each accepted commit loads a new code and raises a one-cycle update strobe. The same register is also formatted into the voltage field of read responses, at the payload width that is in force.

The payload width can be 10, 12 or 16 bits. The 8-bit encoding is reserved because it cannot hold a 10-bit code, and the block treats it as a configuration error. In a second option, a commit only takes effect when the same value has been committed twice in a row. The payload width and the double-commit option are captured while AVS operation is off and are held for as long as it stays on. Commits are ignored outside AVS operation and in the startup sub-mode.

Top module: `avs_vwrite_ctrl`

## Requirements
- R1: After reset, `ref_code_o` equals the parameter RST_CODE (default 0), `ref_upd_o` is low, and `rd_field_o` shows that code in the 10-bit layout.
- R2: The payload select encoding is 01 = 10 bits, 10 = 12 bits, 11 = 16 bits. The code is taken from the top 10 bits of the low payload-width bits of `volt_field_i`: [9:0], [11:2] or [15:6]. Field bits above the payload width are ignored.
- R3: With double-commit off, an accepted commit loads the code into `ref_code_o`. `ref_update_o` is high for exactly the one cycle after the commit cycle, and the code stays stable whenever the strobe is low.
- R4: With double-commit on, a first commit produces no update. A second consecutive commit carrying the same 10-bit code produces the update.
- R5: With double-commit on, a second commit whose code differs from the pending one produces no update. It becomes the new pending first transmission.
- R6: While `avs_en_i` and `avs_stup_i` are both high, commits are ignored.
- R7: While `avs_en_i` is low, commits are ignored.
- R8: The payload select and the double-commit setting are sampled only while `avs_en_i` is low. Changes made while it is high have no effect until AVS operation is left and entered again.
- R9: A latched payload select of 00 (reserved 8-bit) suppresses every update.
- R10: `rd_field_o` holds the current code left-aligned within the latched payload width. The lower bits are zero, and the bits above the width are zero.
- R11: Dropping `avs_en_i` discards a pending first transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| volt_field_i | input | FIELD_W (16) | Voltage field of the write frame, right-aligned |
| commit_i | input | 1 | One-cycle commit-write strobe |
| payload_sel_i | input | 2 | Payload width select (00 reserved, 01 = 10, 10 = 12, 11 = 16 bits) |
| dbl_tx_i | input | 1 | Double-commit requirement enable |
| avs_en_i | input | 1 | AVS operation enabled |
| avs_stup_i | input | 1 | Startup sub-mode request (effective only with avs_en_i) |
| ref_code_o | output | CODE_W (10) | Target reference code |
| ref_upd_o | output | 1 | One-cycle strobe when ref_code_o is loaded |
| rd_field_o | output | FIELD_W (16) | Read-back voltage field at the latched width |

## Verification
The bench builds the block with its defaults: a 10-bit code, a 16-bit field and a reset code of 0. These values bring every legal payload width within reach, so the bit slices at 10, 12 and 16 bits and their zero-padded read-back are all exercised against hand-computed codes. Mode gating is covered, including the reserved 8-bit select. Double-commit sequences are also run: matching pairs, a mismatch that re-arms, and a pending value dropped when AVS is left.

// File: rtl/avs_vw_pkg.sv
package avs_vw_pkg;
  typedef enum logic [1:0] {
    PL_RSVD8 = 2'b00,
    PL_10    = 2'b01,
    PL_12    = 2'b10,
    PL_16    = 2'b11
  } payload_e;

  typedef struct packed {
    payload_e sel;
    logic     dbl;
  } avs_cfg_t;

  function automatic int unsigned payload_bits(payload_e s);
    case (s)
      PL_10:   return 10;
      PL_12:   return 12;
      PL_16:   return 16;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/avs_vw_cfg_latch.sv
module avs_vw_cfg_latch
  import avs_vw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       avs_en_i,
  input  logic [1:0] sel_i,
  input  logic       dbl_i,
  output avs_cfg_t   cfg_o
);
  // track while AVS off, freeze while on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o.sel <= PL_10;
      cfg_o.dbl <= 1'b0;
    end else if (!avs_en_i) begin
      cfg_o.sel <= payload_e'(sel_i);
      cfg_o.dbl <= dbl_i;
    end
  end
endmodule

// File: rtl/avs_vw_field_map.sv
module avs_vw_field_map
  import avs_vw_pkg::*;
#(
  parameter int unsigned CODE_W  = 10,
  parameter int unsigned FIELD_W = 16
) (
  input  payload_e            sel_i,
  input  logic [FIELD_W-1:0]  field_i,
  input  logic [CODE_W-1:0]   code_i,
  output logic [CODE_W-1:0]   code_o,
  output logic [FIELD_W-1:0]  rd_field_o,
  output logic                valid_o
);
  int unsigned        bits;
  int unsigned        shamt;
  logic [FIELD_W-1:0] masked;

  always_comb begin
    bits    = payload_bits(sel_i);
    valid_o = (bits >= CODE_W) && (bits <= FIELD_W);
    shamt   = valid_o ? bits - CODE_W : 0;
    for (int i = 0; i < FIELD_W; i++) begin
      masked[i] = field_i[i] & (i < int'(bits));
    end
    code_o     = CODE_W'(masked >> shamt);
    rd_field_o = FIELD_W'(code_i) << shamt;
  end
endmodule

// File: rtl/avs_vw_commit_gate.sv
module avs_vw_commit_gate #(
  parameter int unsigned CODE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              dbl_i,
  input  logic              clear_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              fire_o
);
  logic              pend_v_q;
  logic [CODE_W-1:0] pend_code_q;

  always_comb
    fire_o = accept_i && (!dbl_i || (pend_v_q && (pend_code_q == code_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q    <= 1'b0;
      pend_code_q <= '0;
    end else if (clear_i) begin
      pend_v_q <= 1'b0;
    end else if (accept_i && dbl_i) begin
      if (fire_o) begin
        pend_v_q <= 1'b0;
      end else begin
        // first transmission or mismatch: (re)arm
        pend_v_q    <= 1'b1;
        pend_code_q <= code_i;
      end
    end
  end
endmodule

// File: rtl/avs_vwrite_ctrl.sv
module avs_vwrite_ctrl
  import avs_vw_pkg::*;
#(
  parameter int unsigned        CODE_W   = 10,
  parameter int unsigned        FIELD_W  = 16,
  parameter logic [CODE_W-1:0]  RST_CODE = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FIELD_W-1:0] volt_field_i,
  input  logic               commit_i,
  input  logic [1:0]         payload_sel_i,
  input  logic               dbl_tx_i,
  input  logic               avs_en_i,
  input  logic               avs_stup_i,
  output logic [CODE_W-1:0]  ref_code_o,
  output logic               ref_upd_o,
  output logic [FIELD_W-1:0] rd_field_o
);
  avs_cfg_t          cfg_q;
  payload_e          cfg_sel;
  logic [CODE_W-1:0] new_code;
  logic              map_valid;
  logic              accept;
  logic              fire;

  assign cfg_sel = cfg_q.sel;

  avs_vw_cfg_latch u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .avs_en_i (avs_en_i),
    .sel_i    (payload_sel_i),
    .dbl_i    (dbl_tx_i),
    .cfg_o    (cfg_q)
  );

  avs_vw_field_map #(.CODE_W(CODE_W), .FIELD_W(FIELD_W)) u_map (
    .sel_i      (cfg_sel),
    .field_i    (volt_field_i),
    .code_i     (ref_code_o),
    .code_o     (new_code),
    .rd_field_o (rd_field_o),
    .valid_o    (map_valid)
  );

  assign accept = commit_i && avs_en_i && !avs_stup_i && map_valid;

  avs_vw_commit_gate #(.CODE_W(CODE_W)) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .dbl_i    (cfg_q.dbl),
    .clear_i  (!avs_en_i),
    .code_i   (new_code),
    .fire_o   (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_code_o <= RST_CODE;
      ref_upd_o  <= 1'b0;
    end else begin
      ref_upd_o <= fire;
      if (fire) ref_code_o <= new_code;
    end
  end
endmodule

// File: rtl/avs_vwrite_ctrl_chk.sv
module avs_vwrite_ctrl_chk
  import avs_vw_pkg::*;
#(
  parameter int unsigned CODE_W  = 10,
  parameter int unsigned FIELD_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               commit_i,
  input logic               avs_en_i,
  input logic               avs_stup_i,
  input payload_e           cfg_sel,
  input logic [CODE_W-1:0]  ref_code_o,
  input logic               ref_upd_o,
  input logic [FIELD_W-1:0] rd_field_o
);
  AST_UPD_NEEDS_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_upd_o |-> $past(commit_i && avs_en_i && !avs_stup_i)); // R3
  AST_CODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_upd_o |-> $stable(ref_code_o)); // R3
  AST_STUP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && avs_en_i && avs_stup_i) |=> !ref_upd_o); // R6
  AST_OFF_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !avs_en_i) |=> !ref_upd_o); // R7
  AST_RSVD_NO_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && cfg_sel == PL_RSVD8) |=> !ref_upd_o); // R9
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avs_en_i && $past(avs_en_i)) |=> $stable(cfg_sel)); // R8
  AST_RD_PAD_16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_sel == PL_16) |-> (rd_field_o[5:0] == '0)); // R10
endmodule

bind avs_vwrite_ctrl avs_vwrite_ctrl_chk #(.CODE_W(CODE_W), .FIELD_W(FIELD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .commit_i   (commit_i),
  .avs_en_i   (avs_en_i),
  .avs_stup_i (avs_stup_i),
  .cfg_sel    (cfg_sel),
  .ref_code_o (ref_code_o),
  .ref_upd_o  (ref_upd_o),
  .rd_field_o (rd_field_o)
);

// File: tb/avs_vwrite_ctrl_test.sv
`timescale 1ns/1ps
module avs_vwrite_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] field = '0;
  logic        commit = 1'b0;
  logic [1:0]  sel = 2'b01;
  logic        dbl = 1'b0;
  logic        en = 1'b0;
  logic        stup = 1'b0;
  logic [9:0]  code;
  logic        upd;
  logic [15:0] rd;

  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic [9:0]  exp_q[$];
  logic [9:0]  exp_code = '0;

  always #2.5 clk = ~clk;

  avs_vwrite_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .volt_field_i(field), .commit_i(commit),
    .payload_sel_i(sel), .dbl_tx_i(dbl), .avs_en_i(en), .avs_stup_i(stup),
    .ref_code_o(code), .ref_upd_o(upd), .rd_field_o(rd)
  );

  // monitor: every update strobe must match the next expected item
  always @(negedge clk) begin
    if (rst_n && upd) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R3 unexpected update: actual %h expected none", code);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        if (code !== e) begin
          n_fail++;
          $display("FAIL R2 update code: actual %h expected %h", code, e);
        end
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // drive one commit; push expected code if an update must follow
  task automatic do_commit(logic [15:0] f, bit expect_upd, logic [9:0] e);
    field = f; commit = 1'b1;
    if (expect_upd) begin exp_q.push_back(e); exp_code = e; end
    tick();
    commit = 1'b0;
    tick(2);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reenter(logic [1:0] s, bit d);
    en = 1'b0; tick(); sel = s; dbl = d; tick(); en = 1'b1; tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    chk("R1 code", 32'(code), 32'h0);
    chk("R1 upd", 32'(upd), 32'h0);
    chk("R1 rd", 32'(rd), 32'h0);
    rst_n = 1'b1; tick(2);

    // R7: AVS off, commit ignored
    do_commit(16'h0155, 1'b0, '0);
    chk("R7 code", 32'(code), 32'h0);

    // R3/R2: single, 10-bit
    reenter(2'b01, 1'b0);
    do_commit(16'h0155, 1'b1, 10'h155);
    chk("R10 rd10", 32'(rd), 32'h0155);
    do_commit(16'hFE2A, 1'b1, 10'h22A);            // R2 upper bits ignored
    chk("R10 rd10 hi", 32'(rd), 32'h022A);

    // R2: 12-bit
    reenter(2'b10, 1'b0);
    do_commit(16'h0ABC, 1'b1, 10'h2AF);
    chk("R10 rd12", 32'(rd), 32'h0ABC);
    do_commit(16'hF123, 1'b1, 10'h048);
    chk("R10 rd12 pad", 32'(rd), 32'h0120);

    // R8: select change while enabled has no effect
    sel = 2'b11; tick();
    do_commit(16'h0ABC, 1'b1, 10'h2AF);
    chk("R8 rd still 12", 32'(rd), 32'h0ABC);

    // R2: 16-bit after re-entry
    reenter(2'b11, 1'b0);
    chk("R10 rd16", 32'(rd), 32'hABC0);
    do_commit(16'h1234, 1'b1, 10'h048);
    chk("R10 rd16 b", 32'(rd), 32'h1200);

    // R6: startup sub-mode ignores commits
    stup = 1'b1; tick();
    do_commit(16'hFFC0, 1'b0, '0);
    chk("R6 code", 32'(code), 32'h048);
    stup = 1'b0; tick();

    // R4: double commit
    reenter(2'b01, 1'b1);
    do_commit(16'h0100, 1'b0, '0);
    chk("R4 first no update", 32'(code), 32'h048);
    do_commit(16'h0100, 1'b1, 10'h100);

    // R5: mismatch re-arms
    do_commit(16'h00AA, 1'b0, '0);
    do_commit(16'h00BB, 1'b0, '0);
    chk("R5 mismatch", 32'(code), 32'h100);
    do_commit(16'h00BB, 1'b1, 10'h0BB);

    // R11: leaving AVS drops pending
    do_commit(16'h00CC, 1'b0, '0);
    en = 1'b0; tick(2); en = 1'b1; tick();
    do_commit(16'h00CC, 1'b0, '0);
    chk("R11 pending dropped", 32'(code), 32'h0BB);
    do_commit(16'h00CC, 1'b1, 10'h0CC);

    // R9: reserved select blocks updates
    reenter(2'b00, 1'b0);
    do_commit(16'h03FF, 1'b0, '0);
    do_commit(16'h03FF, 1'b0, '0);
    chk("R9 code", 32'(code), 32'h0CC);

    chk("R3 final code", 32'(code), 32'(exp_code));
    chk("R3 all expected seen", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule